// File: doc/BRIEF.md
# Mode-Programmed Burst Column Address Generator

This block keeps the operating mode of a double-data-rate memory device and turns each burst request into the column addresses that the burst visits. A load-mode command on the command strobes, aimed at the main mode register while every bank is idle, supplies a mode word. The block decodes three settings from that word: burst length, burst type and read latency. Words that are reserved or illegal are refused, an error flag is raised, and the previous setting stays in force.

A one-cycle burst-start pulse supplies a starting column. From the next cycle on, the block presents two column addresses per clock, one for each half of the clock. The addresses wrap inside the aligned block whose size is the burst length. A valid flag and a last flag frame the burst.

A memory controller uses the block beside its data path. The decoded read latency drives the controller's read-return timing. The column pairs feed the column multiplexer.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset no burst is active (beat_valid and beat_last low), mode_err is low, rd_latency is 3, and the burst setting is length 2, sequential.
- R2: A load-mode command is accepted only when cmd_cs_n, cmd_ras_n, cmd_cas_n and cmd_we_n are all low, cmd_bank is 00 and banks_idle is high. Its setting is visible on rd_latency one cycle later, and it applies to bursts started after that.
- R3: Mode word bits [2:0] set the burst length: 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives a full page of 256 columns.
- R4: Mode word bit [3] sets the burst type: 0 is sequential and 1 is interleaved.
- R5: Mode word bits [6:4] set the read latency on rd_latency: 011 gives 3, 100 gives 4, and 101 gives 5.
- R6: An accepted load-mode command is refused in four cases: a reserved length code, a reserved latency code, a full page with interleaved type, or bit [7] (test mode) set. A refused command sets mode_err one cycle later and leaves length, type and latency unchanged. A legal accepted command clears mode_err.
- R7: A mode word has no effect on the settings or on mode_err in three cases: cmd_bank is not 00, banks_idle is low, or any of the four strobes is high.
- R8: The cycle after burst_start, beat_valid is high and beat_cols carries beats 0 (bits [7:0]) and 1 (bits [15:8]). Each following cycle carries the next two beats. The burst lasts burst length / 2 cycles, beat_last is high only in its final cycle, and beat_valid drops the cycle after.
- R9: A sequential burst of length L from column S gives, for beat i, the upper bits of S above log2(L) joined to the low log2(L) bits of (S + i) mod L.
- R10: An interleaved burst gives, for beat i, the upper bits of S joined to the low log2(L) bits of (S XOR i).
- R11: A full-page burst clears bit 0 of the start column, runs 128 cycles, and covers all 256 columns with sequential wraparound.
- R12: A burst_start that arrives during a burst abandons the old burst and starts the new one at beat 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_cs_n | input | 1 | Chip select strobe, active low |
| cmd_ras_n | input | 1 | Row strobe, active low |
| cmd_cas_n | input | 1 | Column strobe, active low |
| cmd_we_n | input | 1 | Write strobe, active low |
| cmd_addr | input | 11 | Address bus carrying the mode word |
| cmd_bank | input | 2 | Bank bits; 00 selects the main mode register |
| banks_idle | input | 1 | High when every bank is precharged |
| burst_start | input | 1 | One-cycle request to begin a burst |
| start_col | input | 8 | Starting column of the requested burst |
| beat_cols | output | 16 | Column pair of the current cycle, lower beat in bits [7:0] |
| beat_valid | output | 1 | beat_cols holds a burst's columns |
| beat_last | output | 1 | The current pair ends the burst |
| rd_latency | output | 3 | Decoded read latency in clocks |
| mode_err | output | 1 | The last accepted mode word was refused |

## Verification
Every result is due exactly one clock edge after its stimulus. A load-mode command shows on rd_latency and mode_err after the edge that samples it, and a burst request shows beats 0 and 1 after the edge that samples burst_start. Each later pair follows one edge apart, and beat_valid drops one edge after the last pair. The bench drives inputs on the falling edge and samples outputs on the next falling edge, so each check falls in the middle of the cycle in which the registered result is due. The cost of each setting is checked by running a full burst after every mode change, comparing every pair and the last flag against a model computed in the bench.

// File: rtl/bag_pkg.sv
package bag_pkg;

   typedef enum logic [0:0] {
      BT_SEQ = 1'b0,
      BT_ILV = 1'b1
   } burst_type_e;

   typedef struct packed {
      logic [3:0]  len_lg;
      burst_type_e btype;
      logic [2:0]  rlat;
   } mode_cfg_t;

   localparam logic [2:0] BLC_2    = 3'b001;
   localparam logic [2:0] BLC_4    = 3'b010;
   localparam logic [2:0] BLC_8    = 3'b011;
   localparam logic [2:0] BLC_PAGE = 3'b111;

   localparam logic [2:0] CLC_3 = 3'b011;
   localparam logic [2:0] CLC_4 = 3'b100;
   localparam logic [2:0] CLC_5 = 3'b101;

   localparam int LEN_FLD_LSB = 0;
   localparam int TYPE_BIT    = 3;
   localparam int LAT_FLD_LSB = 4;
   localparam int TEST_BIT    = 7;

endpackage

// File: rtl/mode_reg_decode.sv
module mode_reg_decode
   import bag_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int BANK_W = 2,
   parameter int COL_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BANK_W-1:0] bank,
   input  logic              banks_idle,
   output mode_cfg_t         cfg_o,
   output logic              err_o
);

   localparam logic [3:0] PAGE_LG = 4'(COL_W);

   if (ADDR_W < 8) begin : g_addr_chk
      $error("mode_reg_decode: ADDR_W must hold the test-mode bit");
   end

   logic       load_cmd;
   logic [3:0] new_lg;
   logic       len_ok;
   logic [2:0] new_lat;
   logic       lat_ok;
   logic       pair_ok;
   logic       word_ok;
   burst_type_e new_bt;
   mode_cfg_t  cfg_q;
   logic       err_q;

   assign load_cmd = !cs_n && !ras_n && !cas_n && !we_n && banks_idle && (bank == '0);

   always_comb begin
      new_lg = 4'd1;
      len_ok = 1'b1;
      case (addr[LEN_FLD_LSB +: 3])
         BLC_2:    new_lg = 4'd1;
         BLC_4:    new_lg = 4'd2;
         BLC_8:    new_lg = 4'd3;
         BLC_PAGE: new_lg = PAGE_LG;
         default:  len_ok = 1'b0;
      endcase
   end

   always_comb begin
      new_lat = 3'd3;
      lat_ok  = 1'b1;
      case (addr[LAT_FLD_LSB +: 3])
         CLC_3:   new_lat = 3'd3;
         CLC_4:   new_lat = 3'd4;
         CLC_5:   new_lat = 3'd5;
         default: lat_ok  = 1'b0;
      endcase
   end

   assign new_bt  = burst_type_e'(addr[TYPE_BIT]);
   assign pair_ok = !((new_bt == BT_ILV) && (addr[LEN_FLD_LSB +: 3] == BLC_PAGE));
   assign word_ok = len_ok && lat_ok && pair_ok && !addr[TEST_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '{len_lg: 4'd1, btype: BT_SEQ, rlat: 3'd3};
         err_q <= 1'b0;
      end else if (load_cmd) begin
         if (word_ok) begin
            cfg_q <= '{len_lg: new_lg, btype: new_bt, rlat: new_lat};
            err_q <= 1'b0;
         end else begin
            err_q <= 1'b1;
         end
      end
   end

   assign cfg_o = cfg_q;
   assign err_o = err_q;

   assert_keep_on_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load_cmd && !word_ok |=> $stable(cfg_q) && err_q);

   assert_ignore_foreign_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !load_cmd |=> $stable(cfg_q) && $stable(err_q));

   assert_lat_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q.rlat >= 3'd3 && cfg_q.rlat <= 3'd5);

   assert_no_page_ilv_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_q.btype == BT_ILV && cfg_q.len_lg == PAGE_LG));

endmodule

// File: rtl/col_map.sv
module col_map
   import bag_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic [3:0]       len_lg_i,
   input  burst_type_e      btype_i,
   output logic [COL_W-1:0] col_o
);

   logic [COL_W-1:0] mask;
   logic [COL_W-1:0] seq_sum;
   logic [COL_W-1:0] ilv_mix;

   assign mask    = ~({COL_W{1'b1}} << len_lg_i);
   assign seq_sum = base_i + beat_i;
   assign ilv_mix = base_i ^ beat_i;

   always_comb begin
      if (btype_i == BT_ILV) col_o = (base_i & ~mask) | (ilv_mix & mask);
      else                   col_o = (base_i & ~mask) | (seq_sum & mask);
   end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
   import bag_pkg::*;
#(
   parameter int COL_W = 8,
   parameter int LANES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic [COL_W-1:0]       start_col_i,
   input  mode_cfg_t              cfg_i,
   output logic [LANES*COL_W-1:0] cols_o,
   output logic                   valid_o,
   output logic                   last_o
);

   localparam logic [3:0]       PAGE_LG   = 4'(COL_W);
   localparam logic [COL_W-1:0] LANE_MASK = COL_W'(LANES - 1);
   localparam logic [COL_W-1:0] STEP      = COL_W'(LANES);

   if (COL_W < 3 || COL_W > 15) begin : g_width_chk
      $error("burst_col_gen: COL_W out of range");
   end
   if (LANES < 1 || LANES > 2) begin : g_lane_chk
      $error("burst_col_gen: LANES must be 1 or 2");
   end

   logic             active_q;
   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] idx_q;
   logic [3:0]       lg_q;
   burst_type_e      bt_q;
   logic [COL_W-1:0] len_mask;
   logic [COL_W-1:0] last_idx;
   logic             at_last;
   logic [COL_W-1:0] start_base;

   assign len_mask   = ~({COL_W{1'b1}} << lg_q);
   assign last_idx   = len_mask & ~LANE_MASK;
   assign at_last    = active_q && (idx_q == last_idx);
   assign start_base = (cfg_i.len_lg == PAGE_LG) ? (start_col_i & ~COL_W'(1)) : start_col_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         base_q   <= '0;
         idx_q    <= '0;
         lg_q     <= 4'd1;
         bt_q     <= BT_SEQ;
      end else if (start_i) begin
         active_q <= 1'b1;
         base_q   <= start_base;
         idx_q    <= '0;
         lg_q     <= cfg_i.len_lg;
         bt_q     <= cfg_i.btype;
      end else if (active_q) begin
         if (at_last) active_q <= 1'b0;
         else         idx_q    <= idx_q + STEP;
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      col_map #(.COL_W(COL_W)) map_i (
         .base_i   (base_q),
         .beat_i   (idx_q + COL_W'(l)),
         .len_lg_i (lg_q),
         .btype_i  (bt_q),
         .col_o    (cols_o[l*COL_W +: COL_W])
      );
   end

   assign valid_o = active_q;
   assign last_o  = at_last;

   assert_start_beat0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> valid_o && idx_q == '0);

   assert_last_framed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);

   assert_end_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
      last_o && !start_i |=> !valid_o);

   assert_continue_R9: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !last_o && !start_i |=> valid_o);

   assert_page_even_R11: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && lg_q == PAGE_LG |-> !base_q[0]);

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import bag_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int BANK_W = 2,
   parameter int COL_W  = 8,
   parameter int LANES  = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_cs_n,
   input  logic                   cmd_ras_n,
   input  logic                   cmd_cas_n,
   input  logic                   cmd_we_n,
   input  logic [ADDR_W-1:0]      cmd_addr,
   input  logic [BANK_W-1:0]      cmd_bank,
   input  logic                   banks_idle,
   input  logic                   burst_start,
   input  logic [COL_W-1:0]       start_col,
   output logic [LANES*COL_W-1:0] beat_cols,
   output logic                   beat_valid,
   output logic                   beat_last,
   output logic [2:0]             rd_latency,
   output logic                   mode_err
);

   mode_cfg_t cfg;

   mode_reg_decode #(
      .ADDR_W (ADDR_W),
      .BANK_W (BANK_W),
      .COL_W  (COL_W)
   ) mode_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n       (cmd_cs_n),
      .ras_n      (cmd_ras_n),
      .cas_n      (cmd_cas_n),
      .we_n       (cmd_we_n),
      .addr       (cmd_addr),
      .bank       (cmd_bank),
      .banks_idle (banks_idle),
      .cfg_o      (cfg),
      .err_o      (mode_err)
   );

   burst_col_gen #(
      .COL_W (COL_W),
      .LANES (LANES)
   ) gen_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (burst_start),
      .start_col_i (start_col),
      .cfg_i       (cfg),
      .cols_o      (beat_cols),
      .valid_o     (beat_valid),
      .last_o      (beat_last)
   );

   assign rd_latency = cfg.rlat;

   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !beat_valid);

endmodule

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [10:0] addr = '0;
   logic [1:0]  bank = '0;
   logic        idle = 1'b1;
   logic        bstart = 1'b0;
   logic [7:0]  scol = '0;
   logic [15:0] cols;
   logic        bvalid, blast, merr;
   logic [2:0]  rlat;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #5 clk = ~clk;

   burst_addr_gen dut_i (
      .clk(clk), .rst_n(rst_n),
      .cmd_cs_n(cs_n), .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
      .cmd_addr(addr), .cmd_bank(bank), .banks_idle(idle),
      .burst_start(bstart), .start_col(scol),
      .beat_cols(cols), .beat_valid(bvalid), .beat_last(blast),
      .rd_latency(rlat), .mode_err(merr)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [10:0] mw(input logic [2:0] blc, input logic bt,
                                      input logic [2:0] clc, input logic tm);
      return {3'b000, tm, clc, bt, blc};
   endfunction

   function automatic logic [7:0] exp_col(input logic [7:0] st, input int lg,
                                          input logic bt, input int i);
      logic [7:0] mask, b;
      mask = (lg >= 8) ? 8'hFF : 8'((1 << lg) - 1);
      b    = (lg >= 8) ? {st[7:1], 1'b0} : st;
      if (bt) return (b & ~mask) | ((b ^ 8'(i)) & mask);
      return (b & ~mask) | ((b + 8'(i)) & mask);
   endfunction

   task automatic issue(input logic [3:0] strobes, input logic [1:0] bk,
                        input logic [10:0] a, input logic idl);
      @(negedge clk);
      {cs_n, ras_n, cas_n, we_n} = strobes;
      bank = bk; addr = a; idle = idl;
      @(negedge clk);
      {cs_n, ras_n, cas_n, we_n} = 4'b1111;
      bank = '0; addr = '0; idle = 1'b1;
   endtask

   task automatic load(input logic [10:0] a);
      issue(4'b0000, 2'b00, a, 1'b1);
   endtask

   task automatic check_beats(input logic [7:0] st, input int lg, input logic bt,
                              input int k, input int n, input string tag);
      check({tag, " valid"}, 32'(bvalid), 32'd1);
      check({tag, " col0"}, 32'(cols[7:0]), 32'(exp_col(st, lg, bt, 2*k)));
      check({tag, " col1"}, 32'(cols[15:8]), 32'(exp_col(st, lg, bt, 2*k+1)));
      check({tag, " last"}, 32'(blast), 32'(k == n-1));
   endtask

   task automatic run_burst(input logic [7:0] st, input int lg, input logic bt, input string tag);
      int n;
      n = (1 << lg) / 2;
      @(negedge clk);
      bstart = 1'b1; scol = st;
      @(negedge clk);
      bstart = 1'b0;
      for (int k = 0; k < n; k++) begin
         if (k > 0) @(negedge clk);
         check_beats(st, lg, bt, k, n, tag);
      end
      @(negedge clk);
      check({tag, " R8 end"}, 32'(bvalid), 32'd0);
   endtask

   task automatic t_reset;
      check("R1 valid", 32'(bvalid), 32'd0);
      check("R1 last", 32'(blast), 32'd0);
      check("R1 lat", 32'(rlat), 32'd3);
      check("R1 err", 32'(merr), 32'd0);
      run_burst(8'h06, 1, 1'b0, "R1 default BL2");
   endtask

   task automatic t_lengths;
      load(mw(3'b010, 1'b0, 3'b100, 1'b0));
      check("R2 R5 lat4", 32'(rlat), 32'd4);
      run_burst(8'h05, 2, 1'b0, "R3 R9 BL4 seq");
      load(mw(3'b011, 1'b0, 3'b011, 1'b0));
      check("R5 lat3", 32'(rlat), 32'd3);
      run_burst(8'h0D, 3, 1'b0, "R3 R9 BL8 seq");
   endtask

   task automatic t_interleave;
      load(mw(3'b011, 1'b1, 3'b101, 1'b0));
      check("R5 lat5", 32'(rlat), 32'd5);
      run_burst(8'h35, 3, 1'b1, "R4 R10 BL8 ilv");
      load(mw(3'b010, 1'b1, 3'b101, 1'b0));
      run_burst(8'hA6, 2, 1'b1, "R4 R10 BL4 ilv");
   endtask

   task automatic t_fullpage;
      load(mw(3'b111, 1'b0, 3'b011, 1'b0));
      check("R3 page err", 32'(merr), 32'd0);
      run_burst(8'h81, 8, 1'b0, "R11 page");
   endtask

   task automatic t_reject;
      load(mw(3'b011, 1'b0, 3'b100, 1'b0));
      load(mw(3'b000, 1'b0, 3'b011, 1'b0));
      check("R6 rsv len err", 32'(merr), 32'd1);
      check("R6 rsv len lat", 32'(rlat), 32'd4);
      load(mw(3'b111, 1'b1, 3'b011, 1'b0));
      check("R6 page ilv err", 32'(merr), 32'd1);
      load(mw(3'b001, 1'b0, 3'b111, 1'b0));
      check("R6 rsv lat err", 32'(merr), 32'd1);
      check("R6 rsv lat kept", 32'(rlat), 32'd4);
      load(mw(3'b001, 1'b0, 3'b101, 1'b1));
      check("R6 test mode err", 32'(merr), 32'd1);
      check("R6 test mode lat", 32'(rlat), 32'd4);
      run_burst(8'h0A, 3, 1'b0, "R6 kept BL8 seq");
      load(mw(3'b010, 1'b0, 3'b100, 1'b0));
      check("R6 clear err", 32'(merr), 32'd0);
   endtask

   task automatic t_ignore;
      load(mw(3'b000, 1'b0, 3'b011, 1'b0));
      check("R7 setup err", 32'(merr), 32'd1);
      issue(4'b0000, 2'b00, mw(3'b011, 1'b1, 3'b101, 1'b0), 1'b0);
      check("R7 busy lat", 32'(rlat), 32'd4);
      check("R7 busy err", 32'(merr), 32'd1);
      issue(4'b0000, 2'b01, mw(3'b011, 1'b1, 3'b101, 1'b0), 1'b1);
      check("R7 ext bank lat", 32'(rlat), 32'd4);
      check("R7 ext bank err", 32'(merr), 32'd1);
      issue(4'b0010, 2'b00, mw(3'b011, 1'b1, 3'b101, 1'b0), 1'b1);
      check("R7 cas high lat", 32'(rlat), 32'd4);
      check("R7 cas high err", 32'(merr), 32'd1);
      issue(4'b1000, 2'b00, mw(3'b011, 1'b1, 3'b101, 1'b0), 1'b1);
      check("R7 cs high lat", 32'(rlat), 32'd4);
      run_burst(8'h13, 2, 1'b0, "R7 kept BL4 seq");
   endtask

   task automatic t_restart;
      load(mw(3'b011, 1'b0, 3'b011, 1'b0));
      @(negedge clk);
      bstart = 1'b1; scol = 8'h00;
      @(negedge clk);
      bstart = 1'b0;
      check_beats(8'h00, 3, 1'b0, 0, 4, "R12 first");
      @(negedge clk);
      check_beats(8'h00, 3, 1'b0, 1, 4, "R12 first");
      bstart = 1'b1; scol = 8'h14;
      @(negedge clk);
      bstart = 1'b0;
      for (int k = 0; k < 4; k++) begin
         if (k > 0) @(negedge clk);
         check_beats(8'h14, 3, 1'b0, k, 4, "R12 restarted");
      end
      @(negedge clk);
      check("R12 end", 32'(bvalid), 32'd0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_lengths();
      t_interleave();
      t_fullpage();
      t_reject();
      t_ignore();
      t_restart();
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule